// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a clock-recovery loop's oscillator runs at the intended frequency. It counts ticks of the divided oscillator clock while it also counts ticks of a comparison source. The comparison source is either a divided reference clock or a rate derived from the incoming data. A measurement window closes after a fixed number of comparison ticks. The oscillator count is then compared with the count the divide setting predicts, and the absolute difference is tested against two thresholds. The loss-of-lock flag releases only when the difference is small. It returns only when the difference is large. Between the two thresholds the flag keeps its state.

Whenever the flag returns, or an external harmonic detector signals that the data has dropped to a lower harmonic, the block sends a one-cycle restart pulse to the frequency-acquisition loop. A sticky status bit records that a loss of lock has happened. Software clears that bit with a write of one followed by a write of zero to a control bit. A second control bit selects whether the output pin shows the live flag or the sticky bit. A small byte-wide register port holds the configuration and returns the status.

Top module: `freq_lock_monitor`

## Requirements
- R1: A window ends after 2^(WIN_LOG2-k) selected comparison ticks, where k is control A bits 5:2 (limited to WIN_LOG2-1). The oscillator count expected over the window is 2^WIN_LOG2. A write to control A aborts the window in progress.
- R2: The live loss-of-lock flag deasserts only at the end of a window whose absolute count error is at most LOCK_CNT = round(2^WIN_LOG2·LOCK_PPM/1e6). With the defaults this is 262.
- R3: An error above LOCK_CNT and at most UNLOCK_CNT leaves the live flag unchanged in both states.
- R4: While the block is locked, an error above UNLOCK_CNT = round(2^WIN_LOG2·UNLOCK_PPM/1e6) (1049 by default) reasserts the flag. In the same cycle `acq_restart` pulses high for one clock.
- R5: A `harm_det` pulse forces the flag high and pulses `acq_restart` on the next clock edge, whatever the state. It also restarts the measurement window.
- R6: Control A bit 0 selects the comparison source: 1 selects `ref_tick`, 0 selects `data_tick`. Control A, at address 0, reads back all eight bits, including the stored range field in bits 7:6.
- R7: Status bit 4, at address 2, is the sticky bit. It sets on every loss-of-lock event (from R4 or R5) and stays set after lock returns. Status bit 0 reads the live flag.
- R8: The sticky bit clears only when a write to control B (address 1) takes bit 6 from 1 to 0. Writing 1 to bit 6 alone does not clear it, and a new event in the same cycle wins over the clear.
- R9: Control B bit 7 selects what `lol_pin` shows: 0 shows the live flag and 1 shows the sticky bit.
- R10: After reset, the live flag is 1, the sticky bit is 0 and both control registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all ticks are one-cycle enables in this domain |
| rst_n | input | 1 | Synchronous active-low reset |
| vco_tick | input | 1 | One tick per divided oscillator cycle |
| ref_tick | input | 1 | One tick per divided reference clock cycle |
| data_tick | input | 1 | One tick per data-derived rate cycle |
| harm_det | input | 1 | Pulse from the harmonic detector |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control A, 1 control B, 2 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| lol_pin | output | 1 | Loss-of-lock indication, live flag or sticky bit |
| acq_restart | output | 1 | One-cycle request to restart frequency acquisition |

## Verification
The oscillator tick rate is set by a fractional accumulator to errors that sit in each region: well inside the release threshold, inside the hysteresis band, and beyond the reassert threshold. The band rate is applied from both the unlocked and the locked state, which separates true hysteresis from a single threshold. A full-rate oscillator is tried with divide fields 1 and 0 to show that the divide field scales the expected count. A data-derived source at half and at quarter rate shows that the source select really changes which ticks close the window.

// File: rtl/freq_lock_pkg.sv
// Package: shared constants and helpers for the frequency lock detector.
// Assumes thresholds are small enough to fit a 32-bit count.
package freq_lock_pkg;

    localparam logic [1:0] ADDR_CTRL_A = 2'd0;
    localparam logic [1:0] ADDR_CTRL_B = 2'd1;
    localparam logic [1:0] ADDR_STATUS = 2'd2;

    localparam int BIT_SRC_SEL   = 0;
    localparam int BIT_STICKY_CL = 6;
    localparam int BIT_PIN_SEL   = 7;
    localparam int BIT_ST_STICKY = 4;

    // Converts a ppm limit into a rounded count difference over a 2^win_log2 window.
    function automatic int unsigned ppm_to_count(input int win_log2, input int ppm);
        longint unsigned prod;
        prod = (longint'(1) << win_log2) * longint'(ppm) + 64'd500000;
        return int'(prod / 64'd1000000);
    endfunction

endpackage

// File: rtl/flk_window.sv
// Measurement window: counts comparison ticks until 2^(WIN_LOG2-k) have been
// seen, then reports |oscillator count - 2^WIN_LOG2| with a one-cycle done.
// Assumes tick inputs are single-cycle enables synchronous to clk.
module flk_window #(
    parameter int WIN_LOG2 = 20,
    parameter int CW       = WIN_LOG2 + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_win,
    input  logic          vco_tick,
    input  logic          base_tick,
    input  logic [3:0]    div_sel,
    output logic          done_o,
    output logic [CW-1:0] err_o
);
    localparam logic [CW-1:0] EXPECTED = CW'(1) << WIN_LOG2;
    localparam logic [CW-1:0] CNT_MAX  = '1;
    localparam int            KMAX     = WIN_LOG2 - 1;

    logic [CW-1:0] ref_cnt, vco_cnt, vco_next, target;
    int            k_eff;

    // Limit the divide field and derive the comparison-tick target.
    always_comb begin
        k_eff  = (int'(div_sel) > KMAX) ? KMAX : int'(div_sel);
        target = CW'(1) << (WIN_LOG2 - k_eff);
    end

    // Saturating next value of the oscillator count.
    assign vco_next = (vco_cnt == CNT_MAX) ? vco_cnt : vco_cnt + CW'(vco_tick);

    // Advance the counters and close the window on the last comparison tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt <= '0;
            vco_cnt <= '0;
            done_o  <= 1'b0;
            err_o   <= '0;
        end else begin
            done_o <= 1'b0;
            if (restart_win) begin
                ref_cnt <= '0;
                vco_cnt <= '0;
            end else if (base_tick && (ref_cnt + CW'(1) == target)) begin
                done_o  <= 1'b1;
                err_o   <= (vco_next >= EXPECTED) ? vco_next - EXPECTED : EXPECTED - vco_next;
                ref_cnt <= '0;
                vco_cnt <= '0;
            end else begin
                vco_cnt <= vco_next;
                if (base_tick) ref_cnt <= ref_cnt + CW'(1);
            end
        end
    end

    // R1: the comparison count never passes the window length.
    p_ref_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cnt < target);

endmodule

// File: rtl/flk_lock_fsm.sv
// Lock state with hysteresis: releases the flag on a small error, reasserts it
// on a large error or a harmonic pulse, pulses restart, keeps the sticky bit.
// Assumes done_i is a one-cycle strobe qualifying err_i.
module flk_lock_fsm #(
    parameter int          CW         = 22,
    parameter int unsigned LOCK_CNT   = 262,
    parameter int unsigned UNLOCK_CNT = 1049
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic [CW-1:0] err_i,
    input  logic          harm_i,
    input  logic          clr_sticky_i,
    output logic          lol_o,
    output logic          restart_o,
    output logic          sticky_o
);
    logic small_err, large_err, loss_evt;

    // Classify the finished window against the two thresholds.
    always_comb begin
        small_err = done_i && (err_i <= CW'(LOCK_CNT));
        large_err = done_i && (err_i >  CW'(UNLOCK_CNT));
        loss_evt  = harm_i || (!lol_o && large_err);
    end

    // Update the live flag and the restart pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lol_o     <= 1'b1;
            restart_o <= 1'b0;
        end else begin
            restart_o <= loss_evt;
            if (loss_evt)                lol_o <= 1'b1;
            else if (lol_o && small_err) lol_o <= 1'b0;
        end
    end

    // Sticky record of loss events; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)            sticky_o <= 1'b0;
        else if (loss_evt)     sticky_o <= 1'b1;
        else if (clr_sticky_i) sticky_o <= 1'b0;
    end

    // R2: release only after a small-error window without a harmonic.
    p_release_small_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lol_o) |-> $past(done_i && err_i <= CW'(LOCK_CNT) && !harm_i));
    // R3: inside the band the flag keeps its value.
    p_band_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !harm_i && err_i > CW'(LOCK_CNT) && err_i <= CW'(UNLOCK_CNT)) |=> $stable(lol_o));
    // R4: each reassertion comes with a restart pulse.
    p_restart_on_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lol_o) |-> restart_o);
    // R5: a harmonic pulse forces loss and restart.
    p_harm_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
        harm_i |=> (lol_o && restart_o));
    // R7: sticky sets with every reassertion.
    p_sticky_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lol_o) |-> sticky_o);
    // R8: sticky only falls after a clear sequence.
    p_sticky_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sticky_o) |-> $past(clr_sticky_i));

endmodule

// File: rtl/flk_regs.sv
// Register port: two control bytes and a status byte; detects the
// bit-6 one-to-zero write on control B that clears the sticky bit.
// Assumes a single-cycle write strobe; reads are combinational.
module flk_regs
    import freq_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    input  logic       lol_live,
    input  logic       sticky,
    output logic [7:0] rdata,
    output logic [7:0] ctrl_a,
    output logic [7:0] ctrl_b,
    output logic       wr_a,
    output logic       clr_sticky
);
    logic wr_b;

    // Decode write strobes and the clear sequence.
    always_comb begin
        wr_a       = we && (addr == ADDR_CTRL_A);
        wr_b       = we && (addr == ADDR_CTRL_B);
        clr_sticky = wr_b && ctrl_b[BIT_STICKY_CL] && !wdata[BIT_STICKY_CL];
    end

    // Hold the control bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_a <= '0;
            ctrl_b <= '0;
        end else begin
            if (wr_a) ctrl_a <= wdata;
            if (wr_b) ctrl_b <= wdata;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL_A: rdata = ctrl_a;
            ADDR_CTRL_B: rdata = ctrl_b;
            ADDR_STATUS: begin
                rdata[0]             = lol_live;
                rdata[BIT_ST_STICKY] = sticky;
            end
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/freq_lock_monitor.sv
// Top: frequency lock detector with hysteresis, sticky status and a selectable
// output source. Assumes all tick inputs are synchronous one-cycle enables.
module freq_lock_monitor
    import freq_lock_pkg::*;
#(
    parameter int WIN_LOG2   = 20,
    parameter int LOCK_PPM   = 250,
    parameter int UNLOCK_PPM = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vco_tick,
    input  logic       ref_tick,
    input  logic       data_tick,
    input  logic       harm_det,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       lol_pin,
    output logic       acq_restart
);
    localparam int          CW         = WIN_LOG2 + 2;
    localparam int unsigned LOCK_CNT   = ppm_to_count(WIN_LOG2, LOCK_PPM);
    localparam int unsigned UNLOCK_CNT = ppm_to_count(WIN_LOG2, UNLOCK_PPM);

    logic [7:0]    ctrl_a, ctrl_b;
    logic          wr_a, clr_sticky, base_tick, restart_win;
    logic          done, lol_live, sticky;
    logic [CW-1:0] err;

    // Pick the comparison source and the window-abort condition.
    always_comb begin
        base_tick   = ctrl_a[BIT_SRC_SEL] ? ref_tick : data_tick;
        restart_win = harm_det || wr_a;
    end

    flk_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .lol_live(lol_live), .sticky(sticky), .rdata(reg_rdata),
        .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .wr_a(wr_a), .clr_sticky(clr_sticky)
    );

    flk_window #(.WIN_LOG2(WIN_LOG2), .CW(CW)) u_win (
        .clk(clk), .rst_n(rst_n), .restart_win(restart_win), .vco_tick(vco_tick),
        .base_tick(base_tick), .div_sel(ctrl_a[5:2]), .done_o(done), .err_o(err)
    );

    flk_lock_fsm #(.CW(CW), .LOCK_CNT(LOCK_CNT), .UNLOCK_CNT(UNLOCK_CNT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .done_i(done), .err_i(err), .harm_i(harm_det),
        .clr_sticky_i(clr_sticky), .lol_o(lol_live), .restart_o(acq_restart),
        .sticky_o(sticky)
    );

    // Output pin source select.
    assign lol_pin = ctrl_b[BIT_PIN_SEL] ? sticky : lol_live;

    // R9: with the select clear, the pin follows a sticky bit only through the live flag.
    p_pin_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_b[BIT_PIN_SEL] && lol_pin) |-> !(sticky && !lol_live));

endmodule

// File: tb/sim_freq_lock_monitor.sv
// Directed bench: small window and wide ppm limits so each scenario is short.
module sim_freq_lock_monitor;
    localparam int WIN    = 11;
    localparam int WAITC  = 14000;
    localparam int DEN    = 2000000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vco_tick = 1'b0, ref_tick = 1'b0, data_tick = 1'b0, harm_det = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       lol_pin, acq_restart;

    int n_tests = 0, n_fail = 0, n_restart = 0;
    int vnum = 1000000;
    int dper = 0;

    always #4 clk = ~clk;

    freq_lock_monitor #(.WIN_LOG2(WIN), .LOCK_PPM(5000), .UNLOCK_PPM(20000)) u0 (
        .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .ref_tick(ref_tick),
        .data_tick(data_tick), .harm_det(harm_det), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lol_pin(lol_pin), .acq_restart(acq_restart)
    );

    // Tick generators driven at the falling edge.
    initial begin
        int acc = 0;
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            acc += vnum;
            if (acc >= DEN) begin vco_tick = 1'b1; acc -= DEN; end
            else vco_tick = 1'b0;
            ref_tick  = (cyc % 2 == 0);
            data_tick = (dper != 0) && (cyc % dper == 0);
        end
    end

    // Count restart pulses away from the active edge.
    initial forever begin
        @(negedge clk);
        if (acq_restart) n_restart++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic settle();
        repeat (WAITC) @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        rd(2'd2, v);  check("R10 status", v, 32'h01);
        rd(2'd0, v);  check("R10 ctrl A", v, 0);
        rd(2'd1, v);  check("R10 ctrl B", v, 0);
        check("R10 pin", int'(lol_pin), 1);
        check("R10 restarts", n_restart, 0);
    endtask

    task automatic t_band_unlocked();
        int v;
        wr(2'd0, 8'h01);
        vnum = 1010000;
        settle();
        check("R3 band keeps unlocked", int'(lol_pin), 1);
        rd(2'd2, v); check("R7 no event yet", v, 32'h01);
    endtask

    task automatic t_acquire();
        int v;
        vnum = 1003000;
        settle();
        check("R2 locks on small error", int'(lol_pin), 0);
        rd(2'd2, v); check("R7 lock leaves sticky low", v, 0);
        check("R4 no restart on lock", n_restart, 0);
    endtask

    task automatic t_band_locked();
        vnum = 1010000;
        settle();
        check("R3 band keeps locked", int'(lol_pin), 0);
        check("R3 no restart", n_restart, 0);
    endtask

    task automatic t_lose();
        int v;
        vnum = 970000;
        settle();
        check("R4 reasserts", int'(lol_pin), 1);
        check("R4 one restart", n_restart, 1);
        rd(2'd2, v); check("R7 sticky set", v, 32'h11);
    endtask

    task automatic t_relock();
        int v;
        vnum = 1000000;
        settle();
        rd(2'd2, v); check("R7 sticky survives relock", v, 32'h10);
    endtask

    task automatic t_pin_sel();
        wr(2'd1, 8'h80);
        @(negedge clk); check("R9 pin shows sticky", int'(lol_pin), 1);
        wr(2'd1, 8'h00);
        @(negedge clk); check("R9 pin shows live", int'(lol_pin), 0);
    endtask

    task automatic t_sticky_clear();
        int v;
        wr(2'd1, 8'h40);
        rd(2'd2, v); check("R8 one alone keeps sticky", v, 32'h10);
        wr(2'd1, 8'h00);
        rd(2'd2, v); check("R8 cleared", v, 0);
    endtask

    task automatic t_harmonic();
        int v;
        @(negedge clk); harm_det = 1'b1;
        @(negedge clk); harm_det = 1'b0;
        check("R5 pin after harmonic", int'(lol_pin), 1);
        check("R5 restart pulse", int'(acq_restart), 1);
        rd(2'd2, v); check("R7 sticky on harmonic", v, 32'h11);
        settle();
        check("R5 relock", int'(lol_pin), 0);
        check("R5 restart count", n_restart, 2);
    endtask

    task automatic t_divide();
        int v;
        vnum = DEN;
        wr(2'd0, 8'hC5);
        rd(2'd0, v); check("R6 ctrl A readback", v, 32'hC5);
        settle();
        check("R1 divide 2 locks full rate", int'(lol_pin), 0);
        check("R1 no restart", n_restart, 2);
        wr(2'd0, 8'hC1);
        settle();
        check("R1 divide 1 rejects full rate", int'(lol_pin), 1);
        check("R4 restart on divide change", n_restart, 3);
    endtask

    task automatic t_source();
        vnum = 1000000;
        wr(2'd0, 8'h01);
        settle();
        check("R6 ref source locks", int'(lol_pin), 0);
        dper = 4;
        wr(2'd0, 8'h00);
        settle();
        check("R6 data source quarter rate unlocks", int'(lol_pin), 1);
        check("R6 restart", n_restart, 4);
        dper = 2;
        settle();
        check("R6 data source half rate locks", int'(lol_pin), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_band_unlocked();
        t_acquire();
        t_band_locked();
        t_lose();
        t_relock();
        t_pin_sel();
        t_sticky_clear();
        t_harmonic();
        t_divide();
        t_source();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule